// File: doc/BRIEF.md
# Configurable Output Macrocell for a Programmable Logic Array

This block is one output cell of a programmable logic array. The array hands it a sum-of-products term, an output-enable product term, and two terms shared by all cells: a synchronous set and an asynchronous reset. Static configuration bits choose how the cell behaves:

- registered or combinational operation;
- inverting or noninverting output;
- in registered mode, whether the value fed back into the array comes from the register or from the pin.

These choices give six distinct configurations.

The cell drives a tri-state pin model as a data value plus an enable. It reads back the resolved pin level, which is the driven value when enabled and the external level otherwise. It returns one feedback bit to the array. A test preload path can force any value into the register. An active-low power-up clear puts the register in its cleared state, so the pin level after power-up follows the chosen polarity.

Top module: `pal_out_cell`

## Requirements
- R1: With `cfg_reg`=1 and `cfg_pol`=1, `pin_o` equals the `sop_term` value captured at the most recent rising clock edge.
- R2: With `cfg_pol`=0, `pin_o` is the complement of the value it would have with `cfg_pol`=1, in both registered and combinational mode.
- R3: With `cfg_reg`=0, `pin_o` follows `sop_term` (polarity applied) in the same cycle, with no clock edge needed.
- R4: When `sset_term`=1 at a rising edge, with no reset and no preload active, the register loads 1. With `cfg_pol`=1 the pin then reads 1, and with `cfg_pol`=0 it reads 0.
- R5: `areset_term`=1 clears the register to 0 at once, without a clock edge. It wins over `sset_term`.
- R6: While `rst_n`=0 the register is 0. A registered active-high cell (`cfg_pol`=1) drives `pin_o` low, and an active-low cell drives it high.
- R7: `pin_oe` equals `oe_term` at all times.
- R8: With `preload_en`=1, the register loads `preload_val` at the rising edge. `areset_term` and `sset_term` are then ignored.
- R9: With `cfg_reg`=1 and `cfg_fb_pin`=0, `fb_out` is the true (uninverted) register value. This holds even while the pin is disabled.
- R10: With `cfg_reg`=1 and `cfg_fb_pin`=1, `fb_out` is the resolved pin level: `pin_o` when `pin_oe`=1, otherwise `pin_ext`.
- R11: With `cfg_reg`=0, `fb_out` is always the resolved pin level, whatever `cfg_fb_pin` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low power-up clear |
| sop_term | input | 1 | Sum-of-products data term |
| oe_term | input | 1 | Output-enable product term |
| sset_term | input | 1 | Shared synchronous-set term |
| areset_term | input | 1 | Shared asynchronous-reset term |
| cfg_reg | input | 1 | 1 = registered, 0 = combinational |
| cfg_pol | input | 1 | 1 = noninverting, 0 = inverting |
| cfg_fb_pin | input | 1 | 1 = pin feedback in registered mode, 0 = register feedback |
| preload_en | input | 1 | Test preload enable |
| preload_val | input | 1 | Value to preload |
| pin_ext | input | 1 | External level on the pin when it is not driven |
| pin_o | output | 1 | Data driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback bit to the array |

## Verification
The set, reset and preload controls can all be active in the same clock cycle. The priority among them is where an error would hide. The bench holds both `sset_term` and `areset_term` high across an edge and expects the register to stay cleared. It then raises `preload_en` together with both terms and expects the preload value to be taken. In each case the result is read on `pin_o` after the edge. Separately, `areset_term` is raised mid-cycle, and `pin_o` is checked before any edge arrives.

// File: rtl/pal_out_cell.sv
module pal_out_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic sop_term,
  input  logic oe_term,
  input  logic sset_term,
  input  logic areset_term,
  input  logic cfg_reg,
  input  logic cfg_pol,
  input  logic cfg_fb_pin,
  input  logic preload_en,
  input  logic preload_val,
  input  logic pin_ext,
  output logic pin_o,
  output logic pin_oe,
  output logic fb_out
);

  logic q;
  logic clr_now;
  logic core;
  logic pin_level;

  // preload masks the asynchronous clear so it can win
  assign clr_now = areset_term & ~preload_en;

  always_ff @(posedge clk or posedge clr_now or negedge rst_n) begin
    if (!rst_n)          q <= 1'b0;
    else if (clr_now)    q <= 1'b0;
    else if (preload_en) q <= preload_val;
    else if (sset_term)  q <= 1'b1;
    else                 q <= sop_term;
  end

  assign core      = cfg_reg ? q : sop_term;
  assign pin_o     = cfg_pol ? core : ~core;
  assign pin_oe    = oe_term;
  assign pin_level = pin_oe ? pin_o : pin_ext;
  assign fb_out    = (cfg_reg && !cfg_fb_pin) ? q : pin_level;

  assert_set_loads_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sset_term && !areset_term && !preload_en) |=> (q || areset_term));

  assert_reset_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (areset_term && !preload_en) |-> (q == 1'b0));

  assert_preload_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> ((q == $past(preload_val)) || areset_term));

  assert_reg_feedback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reg && !cfg_fb_pin) |-> (fb_out == (cfg_pol ? pin_o : ~pin_o)));

  assert_comb_feedback_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_reg && pin_oe) |-> (fb_out == pin_o));

endmodule

// File: tb/sim_pal_out_cell.sv
module sim_pal_out_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sop_term = 1'b0, oe_term = 1'b0, sset_term = 1'b0, areset_term = 1'b0;
  logic cfg_reg = 1'b1, cfg_pol = 1'b1, cfg_fb_pin = 1'b0;
  logic preload_en = 1'b0, preload_val = 1'b0, pin_ext = 1'b0;
  logic pin_o, pin_oe, fb_out;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pal_out_cell u0 (
    .clk(clk), .rst_n(rst_n), .sop_term(sop_term), .oe_term(oe_term),
    .sset_term(sset_term), .areset_term(areset_term), .cfg_reg(cfg_reg),
    .cfg_pol(cfg_pol), .cfg_fb_pin(cfg_fb_pin), .preload_en(preload_en),
    .preload_val(preload_val), .pin_ext(pin_ext), .pin_o(pin_o),
    .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic drive_setup();
    @(negedge clk);
  endtask

  task automatic t_powerup();
    cfg_reg = 1'b1; cfg_pol = 1'b1; sop_term = 1'b1;
    tick();
    chk("R6 active-high low in clear", pin_o, 1'b0);
    cfg_pol = 1'b0; #1;
    chk("R6 active-low high in clear", pin_o, 1'b1);
    drive_setup(); rst_n = 1'b1; cfg_pol = 1'b1; sop_term = 1'b0;
    tick();
    chk("R6 after release", pin_o, 1'b0);
  endtask

  task automatic t_registered();
    drive_setup(); cfg_reg = 1'b1; cfg_pol = 1'b1; sop_term = 1'b1;
    #1 chk("R1 no change before edge", pin_o, 1'b0);
    tick();
    chk("R1 captured 1", pin_o, 1'b1);
    drive_setup(); sop_term = 1'b0;
    tick();
    chk("R1 captured 0", pin_o, 1'b0);
    drive_setup(); cfg_pol = 1'b0; sop_term = 1'b1;
    tick();
    chk("R2 registered inverted", pin_o, 1'b0);
  endtask

  task automatic t_comb();
    drive_setup(); cfg_reg = 1'b0; cfg_pol = 1'b1; sop_term = 1'b0;
    #1 chk("R3 comb follows 0", pin_o, 1'b0);
    sop_term = 1'b1; #1;
    chk("R3 comb follows 1 no edge", pin_o, 1'b1);
    cfg_pol = 1'b0; #1;
    chk("R2 comb inverted", pin_o, 1'b0);
    oe_term = 1'b1; #1;
    chk("R7 enable high", pin_oe, 1'b1);
    oe_term = 1'b0; #1;
    chk("R7 enable low", pin_oe, 1'b0);
  endtask

  task automatic t_set_reset();
    drive_setup(); cfg_reg = 1'b1; cfg_pol = 1'b1; sop_term = 1'b0; sset_term = 1'b1;
    tick();
    chk("R4 set noninverting", pin_o, 1'b1);
    drive_setup(); cfg_pol = 1'b0; #1;
    chk("R4 set inverting", pin_o, 1'b0);
    cfg_pol = 1'b1; sset_term = 1'b0; sop_term = 1'b1;
    tick();
    areset_term = 1'b1; #1;
    chk("R5 clear without edge", pin_o, 1'b0);
    sset_term = 1'b1;
    tick();
    chk("R5 reset beats set", pin_o, 1'b0);
    drive_setup(); areset_term = 1'b0;
    tick();
    chk("R4 set after reset released", pin_o, 1'b1);
    drive_setup(); sset_term = 1'b0; sop_term = 1'b0;
    tick();
  endtask

  task automatic t_preload();
    drive_setup(); cfg_reg = 1'b1; cfg_pol = 1'b1;
    preload_en = 1'b1; preload_val = 1'b1; areset_term = 1'b1; sset_term = 1'b1;
    tick();
    chk("R8 preload 1 over reset", pin_o, 1'b1);
    drive_setup(); areset_term = 1'b0; preload_val = 1'b0;
    tick();
    chk("R8 preload 0 over set", pin_o, 1'b0);
    drive_setup(); preload_en = 1'b0; sset_term = 1'b0; sop_term = 1'b0;
    tick();
  endtask

  task automatic t_feedback();
    drive_setup(); cfg_reg = 1'b1; cfg_pol = 1'b0; cfg_fb_pin = 1'b0;
    sop_term = 1'b1; oe_term = 1'b0; pin_ext = 1'b0;
    tick();
    chk("R9 register fb while tri-stated", fb_out, 1'b1);
    drive_setup(); cfg_fb_pin = 1'b1; pin_ext = 1'b1; #1;
    chk("R10 pin fb external", fb_out, 1'b1);
    pin_ext = 1'b0; #1;
    chk("R10 pin fb external low", fb_out, 1'b0);
    oe_term = 1'b1; #1;
    chk("R10 pin fb driven", fb_out, 1'b0);
    cfg_pol = 1'b1; #1;
    chk("R10 pin fb driven noninverting", fb_out, 1'b1);
    cfg_reg = 1'b0; cfg_fb_pin = 1'b0; oe_term = 1'b0; pin_ext = 1'b0; sop_term = 1'b1; #1;
    chk("R11 comb fb from pin", fb_out, 1'b0);
    oe_term = 1'b1; #1;
    chk("R11 comb fb driven", fb_out, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_powerup();
    t_registered();
    t_comb();
    t_set_reset();
    t_preload();
    t_feedback();
    finish_run();
  end
endmodule